// File: doc/BRIEF.md
# Root Port Ownership Router

This block sits between a set of root-port transceivers and two kinds of host controller: one high-speed controller and a pool of full/low-speed companion controllers. For every port it decides which side owns it, and it shows each side only the devices on the ports that side owns. A device that moves from one side to the other shows up as a disconnect on the side that loses it and as a connect on the side that gains it.

Until high-speed driver software sets the global configured flag, every port is handed to the companions. Setting the flag moves all ports to the high-speed side. Software then writes a per-port owner bit to hand a port whose device is not high speed to a companion. When that device is unplugged, the port falls back to the high-speed side without any software action. Clearing the configured flag returns every port to the companions at once.

Each port's transceiver mux select changes one cycle after the losing side has already been shown the disconnect. This way the losing controller never drives or samples a port it no longer owns.

Top module: `port_owner_router`

## Requirements
- R1: After reset every port is companion-owned, all connect and change outputs are 0, and every `route_cc_o` bit is 1 (1 = routed to companion, 0 = routed to high-speed).
- R2: While `cfg_i` is 0, every port stays companion-owned and owner writes have no effect. An attached device shows on `cc_conn_o` and never on `hs_conn_o`.
- R3: On the first clock edge with `cfg_i` = 1 after it was 0, every port moves to the high-speed side. Attached ports read `hs_conn_o` = 1 and `cc_conn_o` = 0 after that edge, and both sides flag a change.
- R4: With `cfg_i` = 1, a write strobe on one port with data 1 hands that port to the companion, and data 0 takes it back. Only that port's outputs move.
- R5: With `cfg_i` = 1, a detach event on a companion-owned port returns it to the high-speed side at that edge. A later attach on that port then shows on `hs_conn_o`.
- R6: On the edge where `cfg_i` is seen 0 after being 1, every port returns to the companion side. Each attached high-speed-owned port drops `hs_conn_o` and sets its `hs_chg_o`.
- R7: A change bit is set on the edge where that side's connect bit changes and then stays set until a clear strobe for that bit. If a new change occurs in the same cycle as the clear, the set takes priority.
- R8: A port's `route_cc_o` takes its new value one clock after the connect bits reflect the new owner. The side losing the port has shown connect = 0 for at least one cycle before the select moves.
- R9: An attach and a detach on the same port in the same cycle leave the port absent.
- R10: An attach event shows the device on the owning side's connect bit and sets that side's change bit at the next edge. A detach clears the connect bit and sets the change bit.
- R11: `hs_conn_o` and `cc_conn_o` are never both 1 for the same port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | 1 | Global configured flag from high-speed driver software |
| own_wr_i | input | NUM_PORTS | Per-port owner write strobe |
| own_wdata_i | input | NUM_PORTS | Owner write data, 1 = hand to companion |
| attach_i | input | NUM_PORTS | Device attach event pulse from the transceiver |
| detach_i | input | NUM_PORTS | Device detach event pulse from the transceiver |
| hs_clr_i | input | NUM_PORTS | Write-one-to-clear strobe for `hs_chg_o` |
| cc_clr_i | input | NUM_PORTS | Write-one-to-clear strobe for `cc_chg_o` |
| hs_conn_o | output | NUM_PORTS | Connect status seen by the high-speed controller |
| hs_chg_o | output | NUM_PORTS | Sticky connect-change seen by the high-speed controller |
| cc_conn_o | output | NUM_PORTS | Connect status seen by the companion controllers |
| cc_chg_o | output | NUM_PORTS | Sticky connect-change seen by the companion controllers |
| route_cc_o | output | NUM_PORTS | Transceiver mux select, 1 = companion |

## Verification
The assertions assume that attach and detach are one-cycle events that agree with real device presence. They also assume that clear strobes and owner writes are one-cycle pulses, while the configured flag is a level that may change on any edge. The bench drives every event as a single-cycle pulse between edges, keeps `cfg_i` as a held level, and only detaches ports that currently hold a device, except in the deliberate same-cycle attach/detach case.

// File: rtl/port_route_pkg.sv
package port_route_pkg;

  typedef enum logic {
    OWN_HS = 1'b0,
    OWN_CC = 1'b1
  } owner_e;

endpackage

// File: rtl/port_owner_cell.sv
module port_owner_cell
  import port_route_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cfg_i,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic attach_i,
  input  logic detach_i,
  output logic owner_n_o,
  output logic present_n_o,
  output logic owner_q_o
);

  owner_e owner_q, owner_n;
  logic   present_q, present_n;
  logic   cfg_q;

  always_comb begin
    if (detach_i)      present_n = 1'b0;
    else if (attach_i) present_n = 1'b1;
    else               present_n = present_q;
  end

  always_comb begin
    owner_n = owner_q;
    if (!cfg_i)                             owner_n = OWN_CC;
    else if (!cfg_q)                        owner_n = OWN_HS;
    else if (detach_i && owner_q == OWN_CC) owner_n = OWN_HS;
    else if (wr_i)                          owner_n = wdata_i ? OWN_CC : OWN_HS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q   <= OWN_CC;
      present_q <= 1'b0;
      cfg_q     <= 1'b0;
    end else begin
      owner_q   <= owner_n;
      present_q <= present_n;
      cfg_q     <= cfg_i;
    end
  end

  assign owner_n_o   = owner_n;
  assign present_n_o = present_n;
  assign owner_q_o   = owner_q;

  // R2: unconfigured means companion ownership
  a_r2_unconfigured_cc: assert property (@(posedge clk) disable iff (rst)
    !cfg_i |=> owner_q == OWN_CC);

  // R5: removal from a released port hands it back
  a_r5_detach_returns: assert property (@(posedge clk) disable iff (rst)
    (cfg_i && cfg_q && detach_i && owner_q == OWN_CC) |=> owner_q == OWN_HS);

  // R3: configuration edge claims the port
  a_r3_cfg_claims: assert property (@(posedge clk) disable iff (rst)
    (cfg_i && !cfg_q) |=> owner_q == OWN_HS);

  // R9: simultaneous attach and detach leaves the port empty
  a_r9_detach_wins: assert property (@(posedge clk) disable iff (rst)
    (attach_i && detach_i) |=> !present_q);

endmodule

// File: rtl/side_status.sv
module side_status #(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] conn_n_i,
  input  logic [NUM_PORTS-1:0] clr_i,
  output logic [NUM_PORTS-1:0] conn_o,
  output logic [NUM_PORTS-1:0] chg_o
);

  logic [NUM_PORTS-1:0] conn_q, chg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      conn_q <= '0;
      chg_q  <= '0;
    end else begin
      conn_q <= conn_n_i;
      chg_q  <= (conn_n_i ^ conn_q) | (chg_q & ~clr_i);
    end
  end

  assign conn_o = conn_q;
  assign chg_o  = chg_q;

  // R7: uncleared change bits hold
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (|(chg_q & ~clr_i)) |=> ((chg_q & $past(chg_q & ~clr_i)) == $past(chg_q & ~clr_i)));

  // R10: any connect movement leaves a change flag
  a_r10_move_flags: assert property (@(posedge clk) disable iff (rst)
    (|(conn_n_i ^ conn_q)) |=> ((chg_q & $past(conn_n_i ^ conn_q)) == $past(conn_n_i ^ conn_q)));

endmodule

// File: rtl/route_select.sv
module route_select #(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] owner_q_i,
  output logic [NUM_PORTS-1:0] sel_o
);

  logic [NUM_PORTS-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '1;
    else     sel_q <= owner_q_i;
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/port_owner_router.sv
module port_owner_router
  import port_route_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_i,
  input  logic [NUM_PORTS-1:0] own_wr_i,
  input  logic [NUM_PORTS-1:0] own_wdata_i,
  input  logic [NUM_PORTS-1:0] attach_i,
  input  logic [NUM_PORTS-1:0] detach_i,
  input  logic [NUM_PORTS-1:0] hs_clr_i,
  input  logic [NUM_PORTS-1:0] cc_clr_i,
  output logic [NUM_PORTS-1:0] hs_conn_o,
  output logic [NUM_PORTS-1:0] hs_chg_o,
  output logic [NUM_PORTS-1:0] cc_conn_o,
  output logic [NUM_PORTS-1:0] cc_chg_o,
  output logic [NUM_PORTS-1:0] route_cc_o
);

  logic [NUM_PORTS-1:0] owner_n, present_n, owner_q;
  logic [NUM_PORTS-1:0] hs_conn_n, cc_conn_n;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    port_owner_cell i_cell (
      .clk        (clk),
      .rst        (rst),
      .cfg_i      (cfg_i),
      .wr_i       (own_wr_i[p]),
      .wdata_i    (own_wdata_i[p]),
      .attach_i   (attach_i[p]),
      .detach_i   (detach_i[p]),
      .owner_n_o  (owner_n[p]),
      .present_n_o(present_n[p]),
      .owner_q_o  (owner_q[p])
    );

    // R8: select moves only after the losing side already shows no device
    a_r8_cc_after_hs_drop: assert property (@(posedge clk) disable iff (rst)
      $rose(route_cc_o[p]) |-> !$past(hs_conn_o[p]));
    a_r8_hs_after_cc_drop: assert property (@(posedge clk) disable iff (rst)
      $fell(route_cc_o[p]) |-> !$past(cc_conn_o[p]));
  end

  assign hs_conn_n = present_n & ~owner_n;
  assign cc_conn_n = present_n &  owner_n;

  side_status #(.NUM_PORTS(NUM_PORTS)) i_hs_side (
    .clk     (clk),
    .rst     (rst),
    .conn_n_i(hs_conn_n),
    .clr_i   (hs_clr_i),
    .conn_o  (hs_conn_o),
    .chg_o   (hs_chg_o)
  );

  side_status #(.NUM_PORTS(NUM_PORTS)) i_cc_side (
    .clk     (clk),
    .rst     (rst),
    .conn_n_i(cc_conn_n),
    .clr_i   (cc_clr_i),
    .conn_o  (cc_conn_o),
    .chg_o   (cc_chg_o)
  );

  route_select #(.NUM_PORTS(NUM_PORTS)) i_route (
    .clk      (clk),
    .rst      (rst),
    .owner_q_i(owner_q),
    .sel_o    (route_cc_o)
  );

  // R11: a port is never shown to both sides
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    (hs_conn_o & cc_conn_o) == '0);

  // R6: losing configuration removes every device from the high-speed view
  a_r6_cfg_drop_clears_hs: assert property (@(posedge clk) disable iff (rst)
    !cfg_i |=> hs_conn_o == '0);

endmodule

// File: tb/test_port_owner_router.sv
`timescale 1ns/1ps
module test_port_owner_router;
  localparam int N = 4;

  logic clk = 0, rst = 1, cfg = 0;
  logic [N-1:0] wr = '0, wdata = '0, att = '0, det = '0, hclr = '0, cclr = '0;
  logic [N-1:0] hs_conn, hs_chg, cc_conn, cc_chg, sel;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  port_owner_router #(.NUM_PORTS(N)) i_port_owner_router (
    .clk(clk), .rst(rst), .cfg_i(cfg), .own_wr_i(wr), .own_wdata_i(wdata),
    .attach_i(att), .detach_i(det), .hs_clr_i(hclr), .cc_clr_i(cclr),
    .hs_conn_o(hs_conn), .hs_chg_o(hs_chg), .cc_conn_o(cc_conn),
    .cc_chg_o(cc_chg), .route_cc_o(sel));

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag, logic [N-1:0] hc, logic [N-1:0] hg,
                         logic [N-1:0] cc, logic [N-1:0] cg);
    chk({tag, " hs_conn"}, hs_conn, hc);
    chk({tag, " hs_chg"},  hs_chg,  hg);
    chk({tag, " cc_conn"}, cc_conn, cc);
    chk({tag, " cc_chg"},  cc_chg,  cg);
  endtask

  // one cycle of pulses, applied at a falling edge, results sampled at the next one
  task automatic pulse(logic [N-1:0] w, logic [N-1:0] wd, logic [N-1:0] a,
                       logic [N-1:0] d, logic [N-1:0] hc, logic [N-1:0] cc);
    wr = w; wdata = wd; att = a; det = d; hclr = hc; cclr = cc;
    @(negedge clk);
    wr = '0; wdata = '0; att = '0; det = '0; hclr = '0; cclr = '0;
  endtask

  task automatic idle(); @(negedge clk); endtask
  task automatic clear_all(); pulse('0, '0, '0, '0, '1, '1); endtask

  task automatic t_reset();
    chk_all("R1 reset", '0, '0, '0, '0);
    chk("R1 reset route", sel, 4'b1111);
  endtask

  task automatic t_unconfigured();
    pulse('0, '0, 4'b0011, '0, '0, '0);
    chk_all("R10 R2 attach unconfigured", '0, '0, 4'b0011, 4'b0011);
    pulse(4'b0001, 4'b0000, '0, '0, '0, '0);
    chk_all("R2 write ignored", '0, '0, 4'b0011, 4'b0011);
    chk("R2 route stays companion", sel, 4'b1111);
    clear_all();
    chk_all("R7 clear", '0, '0, 4'b0011, '0);
  endtask

  task automatic t_configure();
    cfg = 1; idle(); cfg = 1;
    chk_all("R3 claim", 4'b0011, 4'b0011, '0, 4'b0011);
    chk("R8 route not yet moved", sel, 4'b1111);
    idle();
    chk("R8 route moved", sel, 4'b0000);
    clear_all();
  endtask

  task automatic t_release();
    pulse(4'b0010, 4'b0010, '0, '0, '0, '0);
    chk_all("R4 release", 4'b0001, 4'b0010, 4'b0010, 4'b0010);
    chk("R8 release route lag", sel, 4'b0000);
    idle();
    chk("R8 release route", sel, 4'b0010);
    pulse(4'b0010, 4'b0000, '0, '0, '0, '0);
    chk_all("R4 reclaim", 4'b0011, 4'b0010, '0, 4'b0010);
    pulse(4'b0010, 4'b0010, '0, '0, '0, '0);
    chk_all("R4 release again", 4'b0001, 4'b0010, 4'b0010, 4'b0010);
    clear_all();
  endtask

  task automatic t_sticky();
    pulse('0, '0, 4'b0100, '0, '0, '0);
    chk_all("R10 attach on hs", 4'b0101, 4'b0100, 4'b0010, '0);
    idle();
    chk("R7 holds", hs_chg, 4'b0100);
    pulse('0, '0, 4'b1000, '0, 4'b1100, '0);
    chk("R7 set beats clear", hs_chg, 4'b1000);
    chk("R7 connect after", hs_conn, 4'b1101);
    clear_all();
  endtask

  task automatic t_detach_return();
    pulse('0, '0, '0, 4'b0010, '0, '0);
    chk_all("R5 detach released", 4'b1101, '0, '0, 4'b0010);
    idle();
    chk("R5 R8 route back", sel, 4'b0000);
    pulse('0, '0, 4'b0010, '0, '0, '0);
    chk_all("R5 reattach on hs", 4'b1111, 4'b0010, '0, 4'b0010);
    clear_all();
  endtask

  task automatic t_same_cycle();
    pulse('0, '0, 4'b1000, 4'b1000, '0, '0);
    chk_all("R9 detach wins", 4'b0111, 4'b1000, '0, '0);
    clear_all();
  endtask

  task automatic t_unconfigure();
    cfg = 0; idle();
    chk_all("R6 drop config", '0, 4'b0111, 4'b0111, 4'b0111);
    chk("R8 drop route lag", sel, 4'b0000);
    idle();
    chk("R6 R8 drop route", sel, 4'b1111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle();
    t_reset();
    t_unconfigured();
    t_configure();
    t_release();
    t_sticky();
    t_detach_return();
    t_same_cycle();
    t_unconfigure();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule